// File: doc/BRIEF.md
# Column Skip-or-Convert Pixel Clocker

This block drives the fast column multiplexer of an imaging array for one row. When `start_i` arrives it first puts the fast multiplexer into a known state. Then it keeps every line low for a quiet interval. Then it walks the columns in order, clocking each one with one of two waveforms. A column whose bit in the row mask is clear gets a short skip waveform, which moves the multiplexer past it. A column whose bit is set gets a longer convert waveform, in which an ADC trigger window is held for a precomputed number of time slices on each phase.

All timing is expressed in time slices. One slice lasts `slice_len_i` clock cycles. The ADC window length `adc_slices_i` is the conversion time divided by the slice length, rounded up, and it is computed outside the block. The mask, the slice length and the window length are all captured when a run starts. `done_o` pulses when the row is finished. The ADC itself and the data capture sit outside this block.

Top module: `col_clk`

## Requirements
- R1: While reset is asserted and after it is released, all four clock lines and `done_o` are low until a run starts.
- R2: A run starts at the first clock edge where `start_i` is high and the block is idle. From the next cycle it plays the initialisation steps: 4 slices idle, 4 slices with `fsync_o` high, 4 slices idle, 4 slices with `phi1_o` high, then 5 one-slice idle steps.
- R3: After the initialisation, all lines stay low for 20 slices before the first column.
- R4: The columns are played in order k = 0 to NCOL-1. Column k takes its type from bit NCOL-1-k of the captured mask, so column 0 is bit 31. A set bit means convert and a clear bit means skip.
- R5: The skip waveform for one column is 4 slices idle, 4 slices `phi2_o`, 4 slices idle, 4 slices `phi1_o`, then 1 slice idle.
- R6: The convert waveform for one column runs as follows. First 3 slices idle, 9 slices `phi2_o`, N slices of `phi2_o` with `adc_trig_o`, and N slices of `phi2_o` alone. Then the same shape on `phi1_o`. Then 1 slice idle. N is the captured `adc_slices_i`.
- R7: One slice lasts exactly the captured `slice_len_i` cycles, and the lines change only at slice boundaries.
- R8: `done_o` is high for exactly one cycle, in the cycle after the final idle slice of the last column. All lines are low while it is high. Afterwards the block is idle.
- R9: While a run is in progress, `start_i` is ignored, and changes on `row_mask_i`, `slice_len_i` and `adc_slices_i` have no effect on the waveform.
- R10: An all-zero mask still produces the initialisation, the quiet interval and NCOL skip waveforms.
- R11: At most one of `fsync_o`, `phi1_o` and `phi2_o` is high at a time, and `adc_trig_o` is high only while a phase line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a row when the block is idle |
| row_mask_i | input | NCOL | Convert (1) or skip (0) per column; column 0 is the top bit |
| slice_len_i | input | SLICE_W | Clock cycles per time slice (must be at least 1) |
| adc_slices_i | input | ADC_W | ADC window length N in slices (must be at least 1) |
| phi1_o | output | 1 | Fast-mux phase 1 clock |
| phi2_o | output | 1 | Fast-mux phase 2 clock |
| fsync_o | output | 1 | Fast-mux sync |
| adc_trig_o | output | 1 | ADC trigger window |
| done_o | output | 1 | One-cycle end-of-row pulse |

## Verification
The following are checked on every cycle:
- the three clock lines are mutually exclusive;
- the ADC trigger is never high without a phase line;
- `done_o` is a single-cycle pulse with the lines quiet;
- the captured mask holds for the whole run;
- the lines stay still inside a slice.

The exact step order, the slice counts, the per-column choice taken from bit 31-k, and the stretching of the window by N can only be shown by the bench scenarios. These compare every cycle against a waveform built from the requirements. They use several masks, slice lengths and N values, an all-zero mask, and a run in which `start_i` and the other inputs change partway through.

// File: rtl/col_clk_pkg.sv
package col_clk_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_INIT, PH_QUIET, PH_COLS, PH_DONE
  } phase_e;

  typedef struct packed {
    logic fsync;
    logic phi2;
    logic phi1;
    logic adc;
  } lines_t;

  localparam int INIT_STEPS   = 9;
  localparam int SKIP_STEPS   = 5;
  localparam int CONV_STEPS   = 9;
  localparam int QUIET_SLICES = 20;
endpackage

// File: rtl/col_clk_timer.sv
module col_clk_timer #(
  parameter int SLICE_W = 8,
  parameter int UNIT_W  = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [SLICE_W-1:0] slice_len_i,
  input  logic [UNIT_W-1:0]  dur_i,
  output logic               slice_end_o,
  output logic               step_last_o
);
  logic [SLICE_W-1:0] cyc_q;
  logic [UNIT_W-1:0]  unit_q;

  assign slice_end_o = (cyc_q == slice_len_i - SLICE_W'(1));
  assign step_last_o = slice_end_o && (unit_q == dur_i - UNIT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      unit_q <= '0;
    end else if (!run_i) begin
      cyc_q  <= '0;
      unit_q <= '0;
    end else if (slice_end_o) begin
      cyc_q  <= '0;
      unit_q <= step_last_o ? '0 : unit_q + UNIT_W'(1);
    end else begin
      cyc_q  <= cyc_q + SLICE_W'(1);
    end
  end
endmodule

// File: rtl/col_clk_pattern.sv
module col_clk_pattern
  import col_clk_pkg::*;
#(
  parameter int ADC_W  = 6,
  parameter int UNIT_W = 6
) (
  input  phase_e             phase_i,
  input  logic [3:0]         step_i,
  input  logic               conv_i,
  input  logic [ADC_W-1:0]   adc_n_i,
  output logic [UNIT_W-1:0]  dur_o,
  output lines_t             lines_o
);
  logic [UNIT_W-1:0] n_ext;
  assign n_ext = UNIT_W'(adc_n_i);

  always_comb begin
    dur_o   = UNIT_W'(1);
    lines_o = '0;
    unique case (phase_i)
      PH_INIT: begin
        dur_o = (step_i < 4'd4) ? UNIT_W'(4) : UNIT_W'(1);
        if (step_i == 4'd1) lines_o.fsync = 1'b1;
        if (step_i == 4'd3) lines_o.phi1  = 1'b1;
      end
      PH_QUIET: dur_o = UNIT_W'(QUIET_SLICES);
      PH_COLS: begin
        if (!conv_i) begin
          case (step_i)
            4'd0, 4'd2: dur_o = UNIT_W'(4);
            4'd1: begin dur_o = UNIT_W'(4); lines_o.phi2 = 1'b1; end
            4'd3: begin dur_o = UNIT_W'(4); lines_o.phi1 = 1'b1; end
            default: dur_o = UNIT_W'(1);
          endcase
        end else begin
          // each half: 3 idle, 9 phase, N phase+trigger, N phase
          case (step_i)
            4'd0, 4'd4: dur_o = UNIT_W'(3);
            4'd1: begin dur_o = UNIT_W'(9); lines_o.phi2 = 1'b1; end
            4'd2: begin dur_o = n_ext; lines_o.phi2 = 1'b1; lines_o.adc = 1'b1; end
            4'd3: begin dur_o = n_ext; lines_o.phi2 = 1'b1; end
            4'd5: begin dur_o = UNIT_W'(9); lines_o.phi1 = 1'b1; end
            4'd6: begin dur_o = n_ext; lines_o.phi1 = 1'b1; lines_o.adc = 1'b1; end
            4'd7: begin dur_o = n_ext; lines_o.phi1 = 1'b1; end
            default: dur_o = UNIT_W'(1);
          endcase
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/col_clk.sv
module col_clk
  import col_clk_pkg::*;
#(
  parameter int NCOL    = 32,
  parameter int SLICE_W = 8,
  parameter int ADC_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [NCOL-1:0]    row_mask_i,
  input  logic [SLICE_W-1:0] slice_len_i,
  input  logic [ADC_W-1:0]   adc_slices_i,
  output logic               phi1_o,
  output logic               phi2_o,
  output logic               fsync_o,
  output logic               adc_trig_o,
  output logic               done_o
);
  localparam int COL_W  = (NCOL > 1) ? $clog2(NCOL) : 1;
  localparam int UNIT_W = (ADC_W > 5) ? ADC_W : 5;

  phase_e             phase_q;
  logic [3:0]         step_q;
  logic [COL_W-1:0]   col_q;
  logic [NCOL-1:0]    mask_q;
  logic [SLICE_W-1:0] len_q;
  logic [ADC_W-1:0]   adc_q;

  logic               col_conv;
  logic [3:0]         last_step;
  logic               run;
  logic               slice_end;
  logic               step_last;
  logic [UNIT_W-1:0]  dur;
  lines_t             lines;

  assign col_conv  = mask_q[COL_W'(NCOL-1) - col_q];
  assign last_step = col_conv ? 4'(CONV_STEPS-1) : 4'(SKIP_STEPS-1);
  assign run       = (phase_q == PH_INIT) || (phase_q == PH_QUIET) || (phase_q == PH_COLS);

  col_clk_pattern #(.ADC_W(ADC_W), .UNIT_W(UNIT_W)) u_pat (
    .phase_i (phase_q),
    .step_i  (step_q),
    .conv_i  (col_conv),
    .adc_n_i (adc_q),
    .dur_o   (dur),
    .lines_o (lines)
  );

  col_clk_timer #(.SLICE_W(SLICE_W), .UNIT_W(UNIT_W)) u_tmr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .slice_len_i (len_q),
    .dur_i       (dur),
    .slice_end_o (slice_end),
    .step_last_o (step_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
      col_q   <= '0;
      mask_q  <= '0;
      len_q   <= SLICE_W'(1);
      adc_q   <= ADC_W'(1);
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_INIT;
          step_q  <= '0;
          col_q   <= '0;
          mask_q  <= row_mask_i;
          len_q   <= slice_len_i;
          adc_q   <= adc_slices_i;
        end
        PH_INIT: if (step_last) begin
          if (step_q == 4'(INIT_STEPS-1)) begin
            phase_q <= PH_QUIET;
            step_q  <= '0;
          end else step_q <= step_q + 4'd1;
        end
        PH_QUIET: if (step_last) begin
          phase_q <= PH_COLS;
          step_q  <= '0;
        end
        PH_COLS: if (step_last) begin
          if (step_q == last_step) begin
            step_q <= '0;
            if (col_q == COL_W'(NCOL-1)) phase_q <= PH_DONE;
            else col_q <= col_q + COL_W'(1);
          end else step_q <= step_q + 4'd1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phi1_o     = lines.phi1;
  assign phi2_o     = lines.phi2;
  assign fsync_o    = lines.fsync;
  assign adc_trig_o = lines.adc;
  assign done_o     = (phase_q == PH_DONE);
endmodule

// File: rtl/col_clk_chk.sv
module col_clk_chk
  import col_clk_pkg::*;
#(
  parameter int NCOL = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            phi1_i,
  input logic            phi2_i,
  input logic            fsync_i,
  input logic            adc_i,
  input logic            done_i,
  input phase_e          phase_i,
  input logic [NCOL-1:0] mask_i,
  input logic            slice_end_i
);
  // R11
  lines_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fsync_i, phi1_i, phi2_i}));

  // R11
  adc_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_i |-> (phi1_i || phi2_i));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R8
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !(phi1_i || phi2_i || fsync_i || adc_i));

  // R9
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != PH_IDLE) |=> $stable(mask_i));

  // R7
  slice_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != PH_IDLE && !slice_end_i) |=> $stable({fsync_i, phi2_i, phi1_i, adc_i}));
endmodule

bind col_clk col_clk_chk #(.NCOL(NCOL)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .phi1_i      (phi1_o),
  .phi2_i      (phi2_o),
  .fsync_i     (fsync_o),
  .adc_i       (adc_trig_o),
  .done_i      (done_o),
  .phase_i     (phase_q),
  .mask_i      (mask_q),
  .slice_end_i (slice_end)
);

// File: tb/col_clk_test.sv
module col_clk_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCOL = 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] row_mask_i = '0;
  logic [7:0]  slice_len_i = 8'd1;
  logic [5:0]  adc_slices_i = 6'd1;
  logic        phi1_o, phi2_o, fsync_o, adc_trig_o, done_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  col_clk #(.NCOL(NCOL)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .row_mask_i(row_mask_i),
    .slice_len_i(slice_len_i), .adc_slices_i(adc_slices_i),
    .phi1_o(phi1_o), .phi2_o(phi2_o), .fsync_o(fsync_o),
    .adc_trig_o(adc_trig_o), .done_o(done_o)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL R8 watchdog: actual no done after %0d cycles, expected done", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // encoding {fsync, phi2, phi1, adc}
  task automatic add(int d, logic [3:0] v, int len, string tag);
    repeat (d * len) begin
      exp_q.push_back(v);
      tag_q.push_back(tag);
    end
  endtask

  task automatic build(logic [31:0] mask, int len, int n, string ovr);
    string t;
    add(4, 4'h0, len, "R2"); add(4, 4'h8, len, "R2");
    add(4, 4'h0, len, "R2"); add(4, 4'h2, len, "R2");
    repeat (5) add(1, 4'h0, len, "R2");
    add(20, 4'h0, len, "R3");
    for (int k = 0; k < NCOL; k++) begin
      if (mask[31-k]) begin
        t = (ovr != "") ? ovr : "R6";
        add(3, 4'h0, len, t); add(9, 4'h4, len, t);
        add(n, 4'h5, len, t); add(n, 4'h4, len, t);
        add(3, 4'h0, len, t); add(9, 4'h2, len, t);
        add(n, 4'h3, len, t); add(n, 4'h2, len, t);
        add(1, 4'h0, len, t);
      end else begin
        t = (ovr != "") ? ovr : "R5";
        add(4, 4'h0, len, t); add(4, 4'h4, len, t);
        add(4, 4'h0, len, t); add(4, 4'h2, len, t);
        add(1, 4'h0, len, t);
      end
    end
  endtask

  task automatic run(logic [31:0] mask, int len, int n, string ovr, bit disturb);
    logic [3:0] obs;
    int idx;
    build(mask, len, n, ovr);
    @(negedge clk);
    row_mask_i = mask; slice_len_i = 8'(len); adc_slices_i = 6'(n); start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    idx = 0;
    while (exp_q.size() > 0) begin
      obs = {fsync_o, phi2_o, phi1_o, adc_trig_o};
      chk(obs == exp_q[0] && !done_o, tag_q[0], {27'd0, done_o, obs}, {28'd0, exp_q[0]});
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
      // R9: restart attempt and new inputs mid-run must be ignored
      if (disturb && idx == 50) begin
        start_i = 1'b1; row_mask_i = ~mask;
        slice_len_i = 8'(len + 1); adc_slices_i = 6'(n + 1);
      end else if (disturb && idx == 53) start_i = 1'b0;
      idx++;
      @(negedge clk);
    end
    obs = {fsync_o, phi2_o, phi1_o, adc_trig_o};
    chk(done_o && obs == 4'h0, "R8", {27'd0, done_o, obs}, 32'h10);
    @(negedge clk);
    obs = {fsync_o, phi2_o, phi1_o, adc_trig_o};
    chk(!done_o && obs == 4'h0, "R8", {27'd0, done_o, obs}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({fsync_o, phi2_o, phi1_o, adc_trig_o, done_o} == 5'd0, "R1",
        {27'd0, fsync_o, phi2_o, phi1_o, adc_trig_o, done_o}, 32'h0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk({fsync_o, phi2_o, phi1_o, adc_trig_o, done_o} == 5'd0, "R1",
        {27'd0, fsync_o, phi2_o, phi1_o, adc_trig_o, done_o}, 32'h0);
    // R10: all-zero mask
    run(32'h0000_0000, 1, 1, "R10", 1'b0);
    // R5 and R6 mixed runs, R7 with two cycles per slice
    run(32'hA5F0_0F0F, 2, 3, "", 1'b0);
    // R4: only first and last columns convert
    run(32'h8000_0001, 1, 4, "R4", 1'b0);
    // R7 and R9: three cycles per slice, inputs disturbed mid-run
    run(32'hFFFF_FFFF, 3, 2, "R9", 1'b1);
    // back-to-back run after done
    run(32'h0000_FFFF, 1, 1, "", 1'b0);
    summary();
    $finish;
  end
endmodule